// File: doc/BRIEF.md
# Software-Managed Translation Buffer

This block holds a fully associative table of address translations that supervisor software loads and inspects one entry at a time. Every entry is reached through three 32-bit words, picked by a word selector. The first word holds the virtual page, the page size, the address-space bit and the valid flag. The second word holds the real page. The third word holds the attribute byte and six access rights. A write that disturbs a live translation raises a one-cycle flush request, so that any shadow translation state held elsewhere can be discarded.

A lookup port translates an effective address for an instruction fetch, a data read or a data write. It applies the user or supervisor rights and the instruction-space or data-space mode bit. It returns a real address or a fault status. A separate search port returns the index of the lowest entry whose page and process ID match, or all ones when nothing matches. Its recording form also produces a 4-bit condition field.

All three ports answer in the cycle after the request is sampled. They see the table as it stood before any write made in that same cycle.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry is invalid and holds zero in all fields, and every registered output is low. A lookup then reports status 1 (no match). Reading word 0 of any entry returns 0.
- R2: A word-0 write stores the page number from bits 31:10, the size code from bits 7:4, the address-space bit from bit 8 and the valid bit from bit 9, and loads the entry's process ID from `cur_pid_i`. Size codes above 9 are stored as 1. A word-0 read returns those fields in the same positions, with bits 3:0 at zero, and pulses `pid_ld_o` with the entry's process ID on `pid_ld_val_o`.
- R3: A word-1 write stores the data ANDed with 0xFFFFFC0F as the real page word, and a word-1 read returns it unchanged.
- R4: A word-2 write stores bits 15:8 as attributes and bits 5:0 as rights, replacing all old rights: bit 0 user read, bit 1 user write, bit 2 user execute, bit 3 supervisor read, bit 4 supervisor write, bit 5 supervisor execute. It leaves the valid bit untouched. A word-2 read returns the attributes at 15:8 and the rights at 5:0, with other bits zero.
- R5: Word selector 3 on a read or a write pulses `mg_illegal_o`, changes no entry, raises no flush and returns no read data.
- R6: A word-0 write to a valid entry raises `flush_req_o` when the page number changes, when the size code grows, or when the new valid bit is 0. It raises nothing when the size shrinks or stays the same with the same page, or when the entry was invalid.
- R7: A word-1 write raises `flush_req_o` only when the entry is valid and its stored real page word changes.
- R8: An entry matches an address when it is valid, its process ID is 0 or equals `cur_pid_i`, and the address bits above bit 10+2n agree with its page number, where n is the size code (a page of 1 KiB times 4 to the power n).
- R9: A successful lookup uses the lowest-index entry that matches and grants the access. The real address takes the real page bits above the page offset and the effective address bits inside the page.
- R10: User-mode lookups use the user rights, and supervisor-mode lookups use the supervisor rights.
- R11: A fetch considers only entries whose address-space bit equals `lk_ispace_i`. It needs execute rights. If such an entry matches but none grants execute, the status is 3 (execute fault).
- R12: A data access considers only entries whose address-space bit equals `lk_dspace_i`. A read needs read rights and a write needs write rights. If such an entry matches but none grants the access, the status is 2 (protection fault). If no entry matches, the status is 1. Success is status 0.
- R13: A search returns the lowest matching index (by R8 without the space check), or 0xFFFFFFFF on a miss. In recording form `sr_cr_we_o` is high and `sr_cr_o` carries the found flag at bit 1 and `sr_so_i` at bit 0, with bits 3:2 zero. Without recording, `sr_cr_we_o` stays low.
- R14: Each lookup, search, read and illegal response appears exactly one cycle after its request. Flush requests also appear one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pid_i | input | 8 | Current process ID |
| mg_wr_i | input | 1 | Entry word write request |
| mg_rd_i | input | 1 | Entry word read request |
| mg_word_i | input | 2 | Word selector (0, 1, 2 legal) |
| mg_idx_i | input | 6 | Entry index (low bits of the index operand) |
| mg_wdata_i | input | 32 | Write data |
| mg_rdata_o | output | 32 | Read data |
| mg_rvalid_o | output | 1 | Read data valid |
| mg_illegal_o | output | 1 | Illegal word selector pulse |
| pid_ld_o | output | 1 | Load the PID register from `pid_ld_val_o` |
| pid_ld_val_o | output | 8 | Process ID of the entry read |
| flush_req_o | output | 1 | One-cycle flush request |
| lk_req_i | input | 1 | Lookup request |
| lk_ea_i | input | 32 | Effective address |
| lk_fetch_i | input | 1 | 1 for instruction fetch |
| lk_write_i | input | 1 | 1 for data write, 0 for data read |
| lk_user_i | input | 1 | 1 for user mode |
| lk_ispace_i | input | 1 | Instruction-space mode bit |
| lk_dspace_i | input | 1 | Data-space mode bit |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_stat_o | output | 2 | 0 ok, 1 no match, 2 protection, 3 execute fault |
| lk_ra_o | output | 32 | Real address |
| sr_req_i | input | 1 | Search request |
| sr_page_i | input | 22 | Address bits 31:10 to search |
| sr_rec_i | input | 1 | Recording form |
| sr_so_i | input | 1 | Summary-overflow bit |
| sr_valid_o | output | 1 | Search result valid |
| sr_idx_o | output | 32 | Matching index or all ones |
| sr_cr_we_o | output | 1 | Condition field write enable |
| sr_cr_o | output | 4 | Condition field |

## Verification
The assertions check, on every cycle, the properties that hold locally. A flush only follows a word-0 or word-1 write. An illegal pulse follows selector 3 and carries no data or flush. A PID load only follows a word-0 read. Each port answers one cycle after its request. A successful translation keeps the low ten address bits. The found flag agrees with the returned index. The exact field layouts, the flush conditions, the size masking, the process ID rules, the choice of user or supervisor rights and the lowest permitting entry all depend on earlier writes, so only the bench's write-then-read and write-then-lookup sequences show them.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

    localparam int AW      = 32;
    localparam int OFS_LSB = 10;
    localparam int VPN_W   = AW - OFS_LSB;
    localparam int PID_W   = 8;
    localparam int SZ_W    = 4;
    localparam int ATTR_W  = 8;
    localparam int PERM_W  = 6;
    localparam int SZ_MAX  = 9;
    localparam logic [AW-1:0] RPN_KEEP = 32'hFFFF_FC0F;

    typedef struct packed {
        logic              valid;
        logic              aspace;
        logic [SZ_W-1:0]   size;
        logic [VPN_W-1:0]  vpn;
        logic [AW-1:0]     rpn;
        logic [ATTR_W-1:0] attr;
        logic [PERM_W-1:0] perm;
        logic [PID_W-1:0]  pid;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        LK_OK     = 2'd0,
        LK_MISS   = 2'd1,
        LK_PROT   = 2'd2,
        LK_NOEXEC = 2'd3
    } lk_stat_e;

    // codes past the largest page collapse to code 1
    function automatic logic [SZ_W-1:0] norm_size(input logic [SZ_W-1:0] c);
        return (c > SZ_W'(SZ_MAX)) ? SZ_W'(1) : c;
    endfunction

    // page-number bits that take part in the compare
    function automatic logic [VPN_W-1:0] vpn_mask(input logic [SZ_W-1:0] c);
        logic [VPN_W-1:0] m;
        m = '1;
        m = m << (2 * c);
        return m;
    endfunction

    // {exec, write, read} for the current privilege level
    function automatic logic [2:0] rights(input logic [PERM_W-1:0] p, input logic user);
        return user ? p[2:0] : p[5:3];
    endfunction

endpackage

// File: rtl/stlb_store.sv
module stlb_store
    import stlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_word_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [AW-1:0]    wr_data_i,
    input  logic [PID_W-1:0] cur_pid_i,
    output tlb_ent_t         ents_o [ENTRIES],
    output logic             flush_o
);

    tlb_ent_t        cur, nxt;
    logic            fl;
    logic            legal;
    logic [SZ_W-1:0] nsz;
    logic [AW-1:0]   nrpn;

    assign legal = (wr_word_i != 2'd3);

    always_comb begin
        cur  = ents_o[wr_idx_i];
        nxt  = cur;
        fl   = 1'b0;
        nsz  = norm_size(wr_data_i[7:4]);
        nrpn = wr_data_i & RPN_KEEP;
        case (wr_word_i)
            2'd0: begin
                nxt.vpn    = wr_data_i[AW-1:OFS_LSB];
                nxt.size   = nsz;
                nxt.aspace = wr_data_i[8];
                nxt.valid  = wr_data_i[9];
                nxt.pid    = cur_pid_i;
                fl = cur.valid && ((cur.vpn != wr_data_i[AW-1:OFS_LSB]) ||
                                   (nsz > cur.size) || !wr_data_i[9]);
            end
            2'd1: begin
                nxt.rpn = nrpn;
                fl = cur.valid && (cur.rpn != nrpn);
            end
            2'd2: begin
                nxt.attr = wr_data_i[15:8];
                nxt.perm = wr_data_i[PERM_W-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ents_o[i] <= '0;
            flush_o <= 1'b0;
        end else begin
            flush_o <= wr_en_i && legal && fl;
            if (wr_en_i && legal) ents_o[wr_idx_i] <= nxt;
        end
    end

endmodule

// File: rtl/stlb_first.sv
module stlb_first #(
    parameter int N  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import stlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       cur_pid_i,
    input  logic             mg_wr_i,
    input  logic             mg_rd_i,
    input  logic [1:0]       mg_word_i,
    input  logic [IDX_W-1:0] mg_idx_i,
    input  logic [31:0]      mg_wdata_i,
    output logic [31:0]      mg_rdata_o,
    output logic             mg_rvalid_o,
    output logic             mg_illegal_o,
    output logic             pid_ld_o,
    output logic [7:0]       pid_ld_val_o,
    output logic             flush_req_o,
    input  logic             lk_req_i,
    input  logic [31:0]      lk_ea_i,
    input  logic             lk_fetch_i,
    input  logic             lk_write_i,
    input  logic             lk_user_i,
    input  logic             lk_ispace_i,
    input  logic             lk_dspace_i,
    output logic             lk_valid_o,
    output logic [1:0]       lk_stat_o,
    output logic [31:0]      lk_ra_o,
    input  logic             sr_req_i,
    input  logic [21:0]      sr_page_i,
    input  logic             sr_rec_i,
    input  logic             sr_so_i,
    output logic             sr_valid_o,
    output logic [31:0]      sr_idx_o,
    output logic             sr_cr_we_o,
    output logic [3:0]       sr_cr_o
);

    tlb_ent_t         ents [ENTRIES];
    logic [ENTRIES-1:0] am_lk, sp_lk, ok_lk, am_sr;
    logic             spc;
    logic             lk_found, sr_found;
    logic [IDX_W-1:0] lk_idx, sr_idx;
    tlb_ent_t         sel, rs;
    logic [AW-1:0]    pmask, ra;
    lk_stat_e         stat;
    logic [AW-1:0]    rword;
    logic             illegal;

    stlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (mg_wr_i),
        .wr_word_i (mg_word_i),
        .wr_idx_i  (mg_idx_i),
        .wr_data_i (mg_wdata_i),
        .cur_pid_i (cur_pid_i),
        .ents_o    (ents),
        .flush_o   (flush_req_o)
    );

    assign spc = lk_fetch_i ? lk_ispace_i : lk_dspace_i;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic [VPN_W-1:0] m;
        logic             pid_ok;
        logic [2:0]       rt;
        assign m        = vpn_mask(ents[i].size);
        assign pid_ok   = (ents[i].pid == '0) || (ents[i].pid == cur_pid_i);
        assign am_lk[i] = ents[i].valid && pid_ok &&
                          (((ents[i].vpn ^ lk_ea_i[AW-1:OFS_LSB]) & m) == '0);
        assign am_sr[i] = ents[i].valid && pid_ok &&
                          (((ents[i].vpn ^ sr_page_i) & m) == '0);
        assign sp_lk[i] = am_lk[i] && (ents[i].aspace == spc);
        assign rt       = rights(ents[i].perm, lk_user_i);
        assign ok_lk[i] = sp_lk[i] &&
                          (lk_fetch_i ? rt[2] : (lk_write_i ? rt[1] : rt[0]));
    end

    stlb_first #(.N(ENTRIES)) u_first_lk (
        .vec_i (ok_lk), .found_o (lk_found), .idx_o (lk_idx)
    );

    stlb_first #(.N(ENTRIES)) u_first_sr (
        .vec_i (am_sr), .found_o (sr_found), .idx_o (sr_idx)
    );

    always_comb begin
        sel   = ents[lk_idx];
        pmask = {vpn_mask(sel.size), {OFS_LSB{1'b0}}};
        ra    = (sel.rpn & pmask) | (lk_ea_i & ~pmask);
        if (lk_found)     stat = LK_OK;
        else if (|sp_lk)  stat = lk_fetch_i ? LK_NOEXEC : LK_PROT;
        else              stat = LK_MISS;
    end

    always_comb begin
        rs = ents[mg_idx_i];
        case (mg_word_i)
            2'd0:    rword = {rs.vpn, rs.valid, rs.aspace, rs.size, 4'b0};
            2'd1:    rword = rs.rpn;
            2'd2:    rword = {16'b0, rs.attr, 2'b0, rs.perm};
            default: rword = '0;
        endcase
    end

    assign illegal = (mg_wr_i || mg_rd_i) && (mg_word_i == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            mg_rdata_o   <= '0;
            mg_rvalid_o  <= 1'b0;
            mg_illegal_o <= 1'b0;
            pid_ld_o     <= 1'b0;
            pid_ld_val_o <= '0;
            lk_valid_o   <= 1'b0;
            lk_stat_o    <= '0;
            lk_ra_o      <= '0;
            sr_valid_o   <= 1'b0;
            sr_idx_o     <= '0;
            sr_cr_we_o   <= 1'b0;
            sr_cr_o      <= '0;
        end else begin
            mg_illegal_o <= illegal;
            mg_rvalid_o  <= mg_rd_i && !illegal;
            mg_rdata_o   <= (mg_rd_i && !illegal) ? rword : '0;
            pid_ld_o     <= mg_rd_i && (mg_word_i == 2'd0);
            pid_ld_val_o <= rs.pid;
            lk_valid_o   <= lk_req_i;
            lk_stat_o    <= stat;
            lk_ra_o      <= (stat == LK_OK) ? ra : '0;
            sr_valid_o   <= sr_req_i;
            sr_idx_o     <= sr_found ? {{(32-IDX_W){1'b0}}, sr_idx} : '1;
            sr_cr_we_o   <= sr_req_i && sr_rec_i;
            sr_cr_o      <= {2'b00, sr_found, sr_so_i};
        end
    end

endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk (
    input logic        clk,
    input logic        rst,
    input logic        mg_wr_i,
    input logic        mg_rd_i,
    input logic [1:0]  mg_word_i,
    input logic        mg_rvalid_o,
    input logic        mg_illegal_o,
    input logic        pid_ld_o,
    input logic        flush_req_o,
    input logic        lk_req_i,
    input logic [31:0] lk_ea_i,
    input logic        lk_valid_o,
    input logic [1:0]  lk_stat_o,
    input logic [31:0] lk_ra_o,
    input logic        sr_req_i,
    input logic        sr_valid_o,
    input logic [31:0] sr_idx_o,
    input logic        sr_cr_we_o,
    input logic [3:0]  sr_cr_o
);

    // R5
    illegal_src_chk: assert property (@(posedge clk) disable iff (rst)
        mg_illegal_o |-> $past((mg_wr_i || mg_rd_i) && mg_word_i == 2'd3));

    // R5
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mg_illegal_o |-> (!mg_rvalid_o && !flush_req_o));

    // R6
    flush_src_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req_o |-> $past(mg_wr_i && (mg_word_i == 2'd0 || mg_word_i == 2'd1)));

    // R2
    pid_ld_src_chk: assert property (@(posedge clk) disable iff (rst)
        pid_ld_o |-> $past(mg_rd_i && mg_word_i == 2'd0));

    // R14
    lk_lat_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(lk_req_i) && !$past(rst)) |-> lk_valid_o);

    // R14
    sr_lat_chk: assert property (@(posedge clk) disable iff (rst)
        sr_valid_o |-> $past(sr_req_i));

    // R9
    lk_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid_o && lk_stat_o == 2'd0) |-> (lk_ra_o[9:0] == $past(lk_ea_i[9:0])));

    // R13
    sr_found_chk: assert property (@(posedge clk) disable iff (rst)
        (sr_valid_o && sr_cr_we_o) |-> (sr_cr_o[1] == (sr_idx_o != 32'hFFFF_FFFF)));

endmodule

bind soft_tlb soft_tlb_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mg_wr_i      (mg_wr_i),
    .mg_rd_i      (mg_rd_i),
    .mg_word_i    (mg_word_i),
    .mg_rvalid_o  (mg_rvalid_o),
    .mg_illegal_o (mg_illegal_o),
    .pid_ld_o     (pid_ld_o),
    .flush_req_o  (flush_req_o),
    .lk_req_i     (lk_req_i),
    .lk_ea_i      (lk_ea_i),
    .lk_valid_o   (lk_valid_o),
    .lk_stat_o    (lk_stat_o),
    .lk_ra_o      (lk_ra_o),
    .sr_req_i     (sr_req_i),
    .sr_valid_o   (sr_valid_o),
    .sr_idx_o     (sr_idx_o),
    .sr_cr_we_o   (sr_cr_we_o),
    .sr_cr_o      (sr_cr_o)
);

// File: tb/tb_soft_tlb.sv
module tb_soft_tlb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cur_pid = '0;
    logic        mg_wr = 0, mg_rd = 0;
    logic [1:0]  mg_word = '0;
    logic [5:0]  mg_idx = '0;
    logic [31:0] mg_wdata = '0;
    logic [31:0] mg_rdata;
    logic        mg_rvalid, mg_illegal, pid_ld, flush_req;
    logic [7:0]  pid_ld_val;
    logic        lk_req = 0, lk_fetch = 0, lk_write = 0, lk_user = 0, lk_is = 0, lk_ds = 0;
    logic [31:0] lk_ea = '0;
    logic        lk_valid;
    logic [1:0]  lk_stat;
    logic [31:0] lk_ra;
    logic        sr_req = 0, sr_rec = 0, sr_so = 0;
    logic [21:0] sr_page = '0;
    logic        sr_valid, sr_cr_we;
    logic [31:0] sr_idx;
    logic [3:0]  sr_cr;

    always #5 clk = ~clk;

    soft_tlb dut (
        .clk(clk), .rst(rst), .cur_pid_i(cur_pid),
        .mg_wr_i(mg_wr), .mg_rd_i(mg_rd), .mg_word_i(mg_word), .mg_idx_i(mg_idx),
        .mg_wdata_i(mg_wdata), .mg_rdata_o(mg_rdata), .mg_rvalid_o(mg_rvalid),
        .mg_illegal_o(mg_illegal), .pid_ld_o(pid_ld), .pid_ld_val_o(pid_ld_val),
        .flush_req_o(flush_req),
        .lk_req_i(lk_req), .lk_ea_i(lk_ea), .lk_fetch_i(lk_fetch), .lk_write_i(lk_write),
        .lk_user_i(lk_user), .lk_ispace_i(lk_is), .lk_dspace_i(lk_ds),
        .lk_valid_o(lk_valid), .lk_stat_o(lk_stat), .lk_ra_o(lk_ra),
        .sr_req_i(sr_req), .sr_page_i(sr_page), .sr_rec_i(sr_rec), .sr_so_i(sr_so),
        .sr_valid_o(sr_valid), .sr_idx_o(sr_idx), .sr_cr_we_o(sr_cr_we), .sr_cr_o(sr_cr)
    );

    typedef struct {
        int          kind;   // 0 write, 1 read, 2 lookup, 3 search
        string       tag;
        logic [31:0] d;
        logic        pl;
        logic [7:0]  pv;
        logic        fl;
        logic        il;
        logic [1:0]  st;
        logic        cw;
        logic [3:0]  cr;
    } exp_t;

    exp_t q[$];
    int   nvec = 0;
    int   nfail = 0;
    bit   done = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: one cycle after each request
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "flush", 32'(flush_req), 32'(e.fl));
                chk(e.tag, "illegal", 32'(mg_illegal), 32'(e.il));
                case (e.kind)
                    1: begin
                        chk(e.tag, "rvalid", 32'(mg_rvalid), 32'(!e.il));
                        if (!e.il) chk(e.tag, "rdata", mg_rdata, e.d);
                        chk(e.tag, "pid_ld", 32'(pid_ld), 32'(e.pl));
                        if (e.pl) chk(e.tag, "pid_val", 32'(pid_ld_val), 32'(e.pv));
                    end
                    2: begin
                        chk(e.tag, "lk_valid", 32'(lk_valid), 32'd1);
                        chk(e.tag, "lk_stat", 32'(lk_stat), 32'(e.st));
                        if (e.st == 2'd0) chk(e.tag, "lk_ra", lk_ra, e.d);
                    end
                    3: begin
                        chk(e.tag, "sr_valid", 32'(sr_valid), 32'd1);
                        chk(e.tag, "sr_idx", sr_idx, e.d);
                        chk(e.tag, "sr_cr_we", 32'(sr_cr_we), 32'(e.cw));
                        if (e.cw) chk(e.tag, "sr_cr", 32'(sr_cr), 32'(e.cr));
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic exp_t blank(int kind, string tag);
        exp_t e;
        e.kind = kind; e.tag = tag; e.d = '0; e.pl = 0; e.pv = '0;
        e.fl = 0; e.il = 0; e.st = '0; e.cw = 0; e.cr = '0;
        return e;
    endfunction

    task automatic idle();
        @(negedge clk);
        mg_wr = 0; mg_rd = 0; lk_req = 0; sr_req = 0;
    endtask

    task automatic wr(logic [1:0] w, logic [5:0] idx, logic [31:0] data,
                      logic exp_fl, logic exp_il, string tag);
        exp_t e;
        @(negedge clk);
        mg_wr = 1; mg_word = w; mg_idx = idx; mg_wdata = data;
        e = blank(0, tag); e.fl = exp_fl; e.il = exp_il;
        q.push_back(e);
        idle();
    endtask

    task automatic rd(logic [1:0] w, logic [5:0] idx, logic [31:0] exp_d,
                      logic [7:0] exp_pid, logic exp_il, string tag);
        exp_t e;
        @(negedge clk);
        mg_rd = 1; mg_word = w; mg_idx = idx;
        e = blank(1, tag); e.d = exp_d; e.il = exp_il;
        e.pl = (w == 2'd0); e.pv = exp_pid;
        q.push_back(e);
        idle();
    endtask

    task automatic lk(logic [31:0] ea, logic fetch, logic write, logic user,
                      logic is, logic ds, logic [1:0] exp_st, logic [31:0] exp_ra, string tag);
        exp_t e;
        @(negedge clk);
        lk_req = 1; lk_ea = ea; lk_fetch = fetch; lk_write = write;
        lk_user = user; lk_is = is; lk_ds = ds;
        e = blank(2, tag); e.st = exp_st; e.d = exp_ra;
        q.push_back(e);
        idle();
    endtask

    task automatic sr(logic [31:0] ea, logic rec, logic so, logic [31:0] exp_idx,
                      logic [3:0] exp_cr, string tag);
        exp_t e;
        @(negedge clk);
        sr_req = 1; sr_page = ea[31:10]; sr_rec = rec; sr_so = so;
        e = blank(3, tag); e.d = exp_idx; e.cw = rec; e.cr = exp_cr;
        q.push_back(e);
        idle();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL R14 watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 idle outputs after reset
        chk("R1", "outputs", {28'b0, flush_req, lk_valid, sr_valid, mg_rvalid}, 32'h0);
        lk(32'h0000_1000, 0, 0, 0, 0, 0, 2'd1, 0, "R1");
        rd(2'd0, 6'd0, 32'h0, 8'h00, 0, "R1");

        // entry 3: 4 KiB page at 0x10000000, PID 5
        cur_pid = 8'd5;
        wr(2'd0, 6'd3, 32'h1000_0210, 0, 0, "R6");
        wr(2'd1, 6'd3, 32'hABCD_E3FF, 1, 0, "R7");
        rd(2'd1, 6'd3, 32'hABCD_E00F, 8'h00, 0, "R3");
        wr(2'd2, 6'd3, 32'hFFFF_A539, 0, 0, "R4");
        rd(2'd2, 6'd3, 32'h0000_A539, 8'h00, 0, "R4");
        rd(2'd0, 6'd3, 32'h1000_0210, 8'd5, 0, "R2");

        // rights and spaces
        lk(32'h1000_0ABC, 0, 0, 1, 0, 0, 2'd0, 32'hABCD_EABC, "R12");
        lk(32'h1000_0ABC, 0, 1, 1, 0, 0, 2'd2, 0, "R10");
        lk(32'h1000_0123, 0, 1, 0, 0, 0, 2'd0, 32'hABCD_E123, "R10");
        lk(32'h1000_0040, 1, 0, 1, 0, 0, 2'd3, 0, "R11");
        lk(32'h1000_0040, 1, 0, 0, 0, 0, 2'd0, 32'hABCD_E040, "R11");
        lk(32'h1000_0040, 1, 0, 0, 1, 0, 2'd1, 0, "R11");
        lk(32'h1000_0040, 0, 0, 0, 0, 1, 2'd1, 0, "R12");
        lk(32'h1000_1000, 0, 0, 0, 0, 0, 2'd1, 0, "R8");
        lk(32'h1000_0C00, 0, 0, 0, 0, 0, 2'd0, 32'hABCD_EC00, "R8");

        // process ID rules and lowest permitting entry
        cur_pid = 8'd7;
        lk(32'h1000_0010, 0, 0, 0, 0, 0, 2'd1, 0, "R8");
        cur_pid = 8'd0;
        wr(2'd0, 6'd10, 32'h1000_0210, 0, 0, "R6");
        wr(2'd1, 6'd10, 32'h5555_5000, 1, 0, "R7");
        wr(2'd2, 6'd10, 32'h0000_0007, 0, 0, "R4");
        cur_pid = 8'd7;
        lk(32'h1000_0010, 0, 1, 1, 0, 0, 2'd0, 32'h5555_5010, "R8");
        cur_pid = 8'd5;
        lk(32'h1000_0010, 0, 1, 1, 0, 0, 2'd0, 32'h5555_5010, "R9");
        lk(32'h1000_0010, 0, 0, 1, 0, 0, 2'd0, 32'hABCD_E010, "R9");

        // search
        sr(32'h1000_0010, 1, 1, 32'd3, 4'b0011, "R13");
        cur_pid = 8'd7;
        sr(32'h1000_0010, 1, 0, 32'd10, 4'b0010, "R13");
        sr(32'h2000_0000, 1, 0, 32'hFFFF_FFFF, 4'b0000, "R13");
        sr(32'h2000_0000, 0, 1, 32'hFFFF_FFFF, 4'b0000, "R13");

        // flush conditions on entry 3
        cur_pid = 8'd5;
        wr(2'd0, 6'd3, 32'h1000_0210, 0, 0, "R6");
        wr(2'd0, 6'd3, 32'h1000_0200, 0, 0, "R6");
        wr(2'd0, 6'd3, 32'h1000_0220, 1, 0, "R6");
        wr(2'd0, 6'd3, 32'h2000_0220, 1, 0, "R6");
        wr(2'd0, 6'd3, 32'h2000_0020, 1, 0, "R6");
        wr(2'd0, 6'd3, 32'h2000_0220, 0, 0, "R6");
        wr(2'd1, 6'd3, 32'hABCD_E00F, 0, 0, "R7");
        wr(2'd1, 6'd30, 32'h1234_5000, 0, 0, "R7");
        lk(32'h2000_3FFC, 0, 0, 0, 0, 0, 2'd0, 32'hABCD_FFFC, "R8");

        // out-of-range size and space bit layout
        wr(2'd0, 6'd20, 32'h3000_03C0, 0, 0, "R2");
        rd(2'd0, 6'd20, 32'h3000_0310, 8'd5, 0, "R2");

        // illegal selector
        wr(2'd3, 6'd3, 32'h0000_0000, 0, 1, "R5");
        rd(2'd0, 6'd3, 32'h2000_0220, 8'd5, 0, "R5");
        rd(2'd3, 6'd3, 32'h0, 8'h00, 1, "R5");

        repeat (3) @(negedge clk);
        chk("R14", "pending", 32'(q.size()), 32'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule